// File: doc/BRIEF.md
# Terminal Bus D-Channel Access Arbiter

This block settles which of several devices on a shared terminal serial bus may send on the common signalling channel. Each frame ends with a control byte that every device can pull low and that reads back as the wired-AND of all drivers. The arbiter steps through that byte one bit slot at a time. In the busy slot it publishes whether it already holds the channel. In the address slots it races its own device address against the other devices. When it wins, it grants the channel to the local link-layer transmitter.

A device that holds the channel keeps the busy slot low until its local request goes away. Any other device may start a race only after the busy slot has read high in a set number of consecutive frames, two by default, so a device that has just released the channel cannot take it straight back. In slave operation the transmitter is cleared to send only while the stop/go slot last read high. Frame timing is generated outside the block, and so is the HDLC engine. The caller presents one strobe for each slot, together with the slot index and the read-back line value.

Top module: `tic_arbiter`

## Requirements
- R1: After reset, `grant` and `cts` are 0. `line_tx` is 1 (released) whenever `bit_stb` is 0. The own address is DEF_ADDR, which is 3'b111 by default.
- R2: Slot 0 of the control byte is the busy slot. A device holding the channel drives it to 0 in every frame. A device that does not hold the channel releases it to 1.
- R3: A race starts in a frame only if `req` is 1, the channel is not held, and the busy slot has read 1 in this frame and in the preceding HOLD_FRAMES-1 frames. A busy slot that reads 0 restarts that count.
- R4: During a race the own address goes out in slots 1..3, most significant bit first in slot 1. Outside a race those slots are released to 1.
- R5: If a slot in which the device drove 1 reads back 0, the device drops out of the race. It releases the remaining address slots of that frame and receives no grant in that frame.
- R6: `grant` rises on the clock edge that ends slot 3, and only if all three address slots read back equal to the own address.
- R7: `grant` stays 1 while `req` is 1. It goes to 0 on the first clock edge at which `req` is 0, and the busy slot is released from the next frame on.
- R8: Because the bus is a wired-AND, the numerically lower address wins a race between two devices. Address 3'b111 therefore has the lowest priority.
- R9: Slot 6 is the stop/go slot, and its read-back value is latched at each occurrence. With `slave_mode`=1, `cts` = `grant` AND the latched value. With `slave_mode`=0, `cts` = `grant`.
- R10: A pulse on `addr_we` loads `addr_in` as the own address, and that address is used in later races.
- R11: Slots 4, 5 (echo) and 7 (A/B) are ignored. The device releases them to 1, and their read-back values leave `grant` and `cts` unchanged.
- R12: If `req` is 0 in the cycle of the last address slot, the race ends without a grant. A device whose hold-off is already met can then win in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One cycle for each control-byte slot |
| bit_pos | input | 3 | Slot index 0..7 for the current strobe |
| line_rx | input | 1 | Wired-AND read-back of the current slot |
| line_tx | output | 1 | Open-drain drive value: 0 pulls the line low, 1 releases it |
| req | input | 1 | Local request for the signalling channel |
| slave_mode | input | 1 | Selects whether the stop/go slot gates `cts` |
| addr_we | input | 1 | Loads `addr_in` as the own address |
| addr_in | input | 3 | New own address |
| grant | output | 1 | The channel is held by this device |
| cts | output | 1 | Clear-to-send for the local transmitter |
| racing | output | 1 | An address race is in progress in this frame |
| won | output | 1 | Pulse: the race is won on this slot |
| lost | output | 1 | Pulse: the race is lost on this slot |

## Verification
Race completion in the last address slot and withdrawal of the local request can fall in the same cycle. The bench provokes this by dropping `req` together with the strobe of slot 3, in a frame where the address would otherwise win. It then expects the own address bits to appear on the line, no grant at the end of the frame, and a clean win in the following frame without any new hold-off. A second case races two devices with different addresses, so that the drop-out in one slot and the release of the later slots are judged against the wired-AND result.

// File: rtl/tic_arb_pkg.sv
package tic_arb_pkg;

  localparam int BUSY_SLOT = 0;

  typedef enum logic [1:0] {
    RACE_IDLE = 2'd0,
    RACE_RUN  = 2'd1,
    RACE_OUT  = 2'd2
  } race_e;

  function automatic int frame_bits(int aw);
    return aw + 5;
  endfunction

  function automatic int sg_slot(int aw);
    return aw + 3;
  endfunction

  function automatic logic is_addr_slot(int pos, int aw);
    return (pos >= 1) && (pos <= aw);
  endfunction

  function automatic logic is_ignored_slot(int pos, int aw);
    return (pos == aw + 1) || (pos == aw + 2) || (pos == aw + 4);
  endfunction

  // Address bit carried by slot pos: slot 1 carries the most significant bit.
  function automatic logic addr_bit_at(logic [15:0] a, int pos, int aw);
    return a[4'(aw - pos)];
  endfunction

endpackage

// File: rtl/tic_holdoff.sv
module tic_holdoff #(
  parameter int HOLD_FRAMES = 2,
  localparam int CNT_W = $clog2(HOLD_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_stb,
  input  logic busy_rx,
  output logic hold_ok
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HOLD_FRAMES);

  logic [CNT_W-1:0] idle_cnt_q;

  // The current frame counts as one of the released frames.
  assign hold_ok = busy_stb && busy_rx && (int'(idle_cnt_q) >= HOLD_FRAMES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_cnt_q <= '0;
    end else if (busy_stb) begin
      if (!busy_rx)
        idle_cnt_q <= '0;
      else if (idle_cnt_q != CNT_MAX)
        idle_cnt_q <= idle_cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/tic_contend.sv
module tic_contend
  import tic_arb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] DEF_ADDR = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  int                pos,
  input  logic              line_rx,
  input  logic              req,
  input  logic              grant,
  input  logic              hold_ok,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              racing,
  output logic              race_tx,
  output logic              won,
  output logic              lost
);

  race_e             race_q;
  logic [ADDR_W-1:0] addr_q;
  logic              addr_stb;
  logic              last_slot;
  logic              own_bit;
  logic              miss;
  logic              start_race;

  assign addr_stb   = bit_stb && is_addr_slot(pos, ADDR_W);
  assign last_slot  = addr_stb && (pos == ADDR_W);
  assign own_bit    = addr_bit_at(16'(addr_q), pos, ADDR_W);
  assign racing     = (race_q == RACE_RUN);
  assign miss       = racing && addr_stb && (line_rx != own_bit);
  assign lost       = miss;
  assign won        = racing && last_slot && !miss && req;
  assign race_tx    = racing ? own_bit : 1'b1;
  assign start_race = req && !grant && hold_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr_q <= DEF_ADDR;
    else if (addr_we)
      addr_q <= addr_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      race_q <= RACE_IDLE;
    end else if (bit_stb && pos == BUSY_SLOT) begin
      race_q <= start_race ? RACE_RUN : RACE_IDLE;
    end else if (racing) begin
      if (!req)
        race_q <= RACE_IDLE;
      else if (miss)
        race_q <= RACE_OUT;
      else if (last_slot)
        race_q <= RACE_IDLE;
    end
  end

  // R3: a race only starts in a frame whose hold-off was met
  a_r3_start_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(racing) |-> $past(hold_ok));

  // R5: a device that dropped out does not re-enter within the frame
  a_r5_out_stays_out: assert property (@(posedge clk) disable iff (!rst_n)
    (race_q == RACE_OUT && !(bit_stb && pos == BUSY_SLOT)) |=> !racing);

endmodule

// File: rtl/tic_grant.sv
module tic_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic won,
  input  logic slave_mode,
  input  logic sg_stb,
  input  logic line_rx,
  output logic grant,
  output logic cts
);

  logic grant_q;
  logic sg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      grant_q <= 1'b0;
    else if (!req)
      grant_q <= 1'b0;
    else if (won)
      grant_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sg_q <= 1'b0;
    else if (sg_stb)
      sg_q <= line_rx;
  end

  assign grant = grant_q;
  assign cts   = grant_q && (!slave_mode || sg_q);

  // R7: withdrawal removes the grant on the next edge
  a_r7_drop_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !grant);

  // R6: the grant only appears after a won race
  a_r6_rise_after_win: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(won));

  // R9: a low stop/go read blocks sending in slave mode
  a_r9_slave_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (sg_stb && !line_rx) |=> (!cts || !slave_mode));

endmodule

// File: rtl/tic_arbiter.sv
module tic_arbiter
  import tic_arb_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] DEF_ADDR = '1,
  parameter int HOLD_FRAMES = 2,
  localparam int POS_W = $clog2(ADDR_W + 5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic [POS_W-1:0]  bit_pos,
  input  logic              line_rx,
  output logic              line_tx,
  input  logic              req,
  input  logic              slave_mode,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              grant,
  output logic              cts,
  output logic              racing,
  output logic              won,
  output logic              lost
);

  int   pos;
  logic busy_stb;
  logic sg_stb;
  logic ign_stb;
  logic hold_ok;
  logic race_tx;

  assign pos      = int'(bit_pos);
  assign busy_stb = bit_stb && (pos == BUSY_SLOT);
  assign sg_stb   = bit_stb && (pos == sg_slot(ADDR_W));
  assign ign_stb  = bit_stb && is_ignored_slot(pos, ADDR_W);

  tic_holdoff #(.HOLD_FRAMES(HOLD_FRAMES)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_stb (busy_stb),
    .busy_rx  (line_rx),
    .hold_ok  (hold_ok)
  );

  tic_contend #(.ADDR_W(ADDR_W), .DEF_ADDR(DEF_ADDR)) u_race (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_stb (bit_stb),
    .pos     (pos),
    .line_rx (line_rx),
    .req     (req),
    .grant   (grant),
    .hold_ok (hold_ok),
    .addr_we (addr_we),
    .addr_in (addr_in),
    .racing  (racing),
    .race_tx (race_tx),
    .won     (won),
    .lost    (lost)
  );

  tic_grant u_grant (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .won        (won),
    .slave_mode (slave_mode),
    .sg_stb     (sg_stb),
    .line_rx    (line_rx),
    .grant      (grant),
    .cts        (cts)
  );

  always_comb begin
    line_tx = 1'b1;
    if (busy_stb)
      line_tx = !grant;
    else if (bit_stb && is_addr_slot(pos, ADDR_W))
      line_tx = race_tx;
  end

  // R2: while held, the busy slot never reads released on the wire
  a_r2_owner_holds_busy: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !(busy_stb && line_rx));

  // R5: after a loss the rest of the address slots are released
  a_r5_release_after_loss: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (line_tx || !bit_stb || !is_addr_slot(int'(bit_pos), ADDR_W)));

  // R11: ignored slots leave the grant alone
  a_r11_ignored_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (ign_stb && req) |=> $stable(grant));

  // R6: racing and holding never overlap
  a_r6_race_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({racing, grant}));

endmodule

// File: tb/tic_arbiter_tb_top.sv
module tic_arbiter_tb_top;

  typedef struct {
    logic [7:0] tx;
    logic       g;
    logic       c;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_stb = 1'b0;
  logic [2:0] bit_pos = '0;
  logic       line_rx;
  logic       line_tx;
  logic       req = 1'b0;
  logic       slave_mode = 1'b0;
  logic       addr_we = 1'b0;
  logic [2:0] addr_in = '0;
  logic       grant, cts, racing, won, lost;
  logic       other_bit = 1'b1;
  logic [7:0] tx_cap;
  exp_t       sb_q[$];
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;
  event       frame_done;

  always #4 clk = ~clk;

  // Wired-AND of this device and the other devices on the bus
  assign line_rx = line_tx & other_bit;

  tic_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_pos(bit_pos),
    .line_rx(line_rx), .line_tx(line_tx), .req(req), .slave_mode(slave_mode),
    .addr_we(addr_we), .addr_in(addr_in), .grant(grant), .cts(cts),
    .racing(racing), .won(won), .lost(lost)
  );

  // Slot image: [0] busy, [1..3] address MSB first, [4],[5],[7] ignored, [6] stop/go
  function automatic logic [7:0] slots(logic busy, logic [2:0] a, logic sg, logic ign);
    logic [7:0] r;
    r[0] = busy; r[1] = a[2]; r[2] = a[1]; r[3] = a[0];
    r[4] = ign;  r[5] = ign;  r[6] = sg;   r[7] = ign;
    return r;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic push(logic [7:0] tx, logic g, logic c, string tag);
    exp_t e;
    e.tx = tx; e.g = g; e.c = c; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Driver: one control byte; req falls at slot drop_at when drop_at >= 0
  task automatic run_frame(logic rq, logic [7:0] others, int drop_at);
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      bit_stb   = 1'b1;
      bit_pos   = 3'(p);
      req       = (drop_at >= 0 && p >= drop_at) ? 1'b0 : rq;
      other_bit = others[p];
      #2 tx_cap[p] = line_tx;
    end
    @(negedge clk);
    bit_stb   = 1'b0;
    other_bit = 1'b1;
    -> frame_done;
    #1;
  endtask

  // Monitor: compares each completed frame against the scoreboard
  initial begin
    forever begin
      @(frame_done);
      if (sb_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1 scoreboard empty actual=0 expected=1");
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " line_tx"}, tx_cap, e.tx);
        chk({e.tag, " grant"}, {7'b0, grant}, {7'b0, e.g});
        chk({e.tag, " cts"}, {7'b0, cts}, {7'b0, e.c});
      end
    end
  end

  task automatic set_req_low(string tag);
    @(negedge clk); req = 1'b0;
    @(negedge clk);
    chk({tag, " grant after release"}, {7'b0, grant}, 8'd0);
    chk({tag, " cts after release"}, {7'b0, cts}, 8'd0);
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    if (!done) $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 grant", {7'b0, grant}, 8'd0);
    chk("R1 cts", {7'b0, cts}, 8'd0);
    chk("R1 line_tx idle", {7'b0, line_tx}, 8'd1);

    // R3: busy slot low, then only one released frame -> no race
    push(8'hFF, 0, 0, "R3 busy low");
    run_frame(1, slots(0, 3'b111, 1, 1), -1);
    push(8'hFF, 0, 0, "R3 one frame");
    run_frame(1, slots(1, 3'b111, 1, 1), -1);
    // R6 R10 R4: second released frame, default address 111 wins
    push(slots(1, 3'b111, 1, 1), 1, 1, "R6 default addr win");
    run_frame(1, slots(1, 3'b111, 1, 1), -1);
    // R2: owner pulls the busy slot low
    push(slots(0, 3'b111, 1, 1), 1, 1, "R2 owner busy");
    run_frame(1, 8'hFF, -1);
    // R7: release
    set_req_low("R7");
    push(8'hFF, 0, 0, "R7 busy released");
    run_frame(0, 8'hFF, -1);
    // R10: load address 010
    @(negedge clk); addr_in = 3'b010; addr_we = 1'b1;
    @(negedge clk); addr_we = 1'b0;
    push(8'hFF, 0, 0, "R10 idle frame");
    run_frame(0, 8'hFF, -1);
    // R8: 010 against 011 -> lower wins
    push(slots(1, 3'b010, 1, 1), 1, 1, "R8 lower addr wins");
    run_frame(1, slots(1, 3'b011, 1, 1), -1);
    set_req_low("R7 second");
    push(8'hFF, 0, 0, "R7 idle");
    run_frame(0, 8'hFF, -1);
    // R5: 010 against 001 -> drops out at slot 2, slot 3 released
    push(slots(1, 3'b011, 1, 1), 0, 0, "R5 drop out");
    run_frame(1, slots(1, 3'b001, 1, 1), -1);
    push(8'hFF, 0, 0, "R3 other owns");
    run_frame(1, slots(0, 3'b111, 1, 1), -1);
    // R9: slave mode, stop/go low
    slave_mode = 1'b1;
    push(8'hFF, 0, 0, "R9 hold-off frame");
    run_frame(1, slots(1, 3'b111, 0, 1), -1);
    push(slots(1, 3'b010, 1, 1), 1, 0, "R9 stop");
    run_frame(1, slots(1, 3'b111, 0, 1), -1);
    // R9 go, R11 ignored slots read low
    push(slots(0, 3'b111, 1, 1), 1, 1, "R11 R9 go");
    run_frame(1, slots(1, 3'b111, 1, 0), -1);
    set_req_low("R7 slave");
    slave_mode = 1'b0;
    push(8'hFF, 0, 0, "R12 idle");
    run_frame(0, 8'hFF, -1);
    // R12: request withdrawn in the last address slot
    push(slots(1, 3'b010, 1, 1), 0, 0, "R12 withdraw");
    run_frame(1, 8'hFF, 3);
    push(slots(1, 3'b010, 1, 1), 1, 1, "R12 next frame win");
    run_frame(1, 8'hFF, -1);
    set_req_low("R7 final");

    chk("R1 scoreboard drained", 8'(sb_q.size()), 8'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule